// File: doc/BRIEF.md
# Configuration Access Address Translator

This block sits in front of a memory-mapped configuration window. Each configuration request names a bus number, a device/function number and a register offset. The block packs these into a window-relative offset and adds a 64-bit window base. In the same step it decides whether the target can be reached at all. Unreachable targets are marked rejected so the surrounding logic can finish them locally: a rejected read returns all-ones data and a rejected write is dropped.

A request is judged unreachable in any of these cases: the translator is disabled; the request is on the root bus and names any device/function other than zero; the request is on a bus other than the root and the link is down; or the bus number is above the last accessible bus. The last accessible bus comes from a size field in the control register. A small register port holds the control register, the two halves of the window base, and a read-only capability word.

Requests use a valid/ready handshake. The block is always ready. The translated address and the verdict are registered and appear on the response port one cycle after the request is taken.

Top module: `cfg_addr_xlate`

## Requirements
- R1: An accepted response carries address = base + ((bus << 20) | (devfn << 12) | offset), where base is {base-high, base-low}. A carry out of the low base half propagates into the high half.
- R2: On the root bus (bus 0), any devfn other than 0 is rejected. Devfn 0 on the root bus is accepted.
- R3: A request on any bus other than the root is rejected when link_up is 0 in the request cycle. It is accepted when link_up is 1 and no other rule rejects it.
- R4: A request whose bus number is greater than the size field of the control register is rejected. Bus numbers up to and including the size field are accepted.
- R5: While the enable bit (control bit 0) is 0, every request is rejected.
- R6: A rejected read gives rsp_data of all ones. A rejected write gives rsp_wr_en 0. Both have rsp_rejected 1. An accepted request gives rsp_rejected 0, rsp_data 0, rsp_wr_en equal to its write flag, and rsp_addr 0 when rejected.
- R7: After reset, rsp_valid is 0, the control register reads 0x000C0000 (disabled, size 12), and both base halves read 0.
- R8: The capability register (reg_sel 0) always reads 1. Writes to it have no effect.
- R9: reg_sel encodes 1 = control, 2 = base low, 3 = base high. Writes to the base halves read back unchanged. A control write keeps only bit 0 (enable) and bits 20:16 (size). All other control bits read 0.
- R10: A register write in the same cycle as a request does not affect that request. The request is judged with the values held before the write, and the new value applies from the next cycle.
- R11: rsp_valid is 1 in exactly the cycle after each request taken with req_valid and req_ready both high, and 0 otherwise. req_ready is always 1, so back-to-back requests each get a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 cap, 1 control, 2 base low, 3 base high) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel (combinational) |
| link_up | input | 1 | Link status, 1 when downstream link is up |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function number |
| req_offset | input | 12 | Register offset within the function |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response valid, one cycle after a request |
| rsp_rejected | output | 1 | Target unreachable; complete locally |
| rsp_write | output | 1 | Write flag of the answered request |
| rsp_wr_en | output | 1 | Write may be issued (accepted write) |
| rsp_addr | output | 64 | Translated window address (0 when rejected) |
| rsp_data | output | 32 | Local completion data (all ones for a rejected read) |

## Verification
A request and a register write can land in the same cycle. The sharpest case is a control write that clears or sets the enable bit, or changes the size field, while a request is presented. The bench provokes this by driving both strobes on one clock edge, in both directions (enable to disable and back). Its model judges the request against the register values it held before applying the write. So the request in the write cycle must follow the old setting and the next request the new one. Each of these outcomes is compared against the response on every clock.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [1:0] {
    SEL_CAP     = 2'd0,
    SEL_CTRL    = 2'd1,
    SEL_BASE_LO = 2'd2,
    SEL_BASE_HI = 2'd3
  } cfgx_sel_e;

  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_SZ_LSB = 16;
  localparam int unsigned CTRL_SZ_W   = 5;

endpackage

// File: rtl/cfgx_regs.sv
module cfgx_regs #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned SIZE_W   = cfgx_pkg::CTRL_SZ_W,
  parameter int unsigned SIZE_LSB = cfgx_pkg::CTRL_SZ_LSB,
  parameter int unsigned SIZE_RST = 12,
  localparam int unsigned BASE_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              en_o,
  output logic [SIZE_W-1:0] last_bus_o,
  output logic [BASE_W-1:0] base_o
);
  import cfgx_pkg::*;

  logic              en_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] base_lo_q;
  logic [DATA_W-1:0] base_hi_q;
  cfgx_sel_e         sel;

  assign sel = cfgx_sel_e'(reg_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      size_q    <= SIZE_W'(SIZE_RST);
      base_lo_q <= '0;
      base_hi_q <= '0;
    end else if (reg_we) begin
      case (sel)
        SEL_CTRL: begin
          en_q   <= reg_wdata[CTRL_EN_BIT];
          size_q <= reg_wdata[SIZE_LSB +: SIZE_W];
        end
        SEL_BASE_LO: base_lo_q <= reg_wdata;
        SEL_BASE_HI: base_hi_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CAP:     reg_rdata[0] = 1'b1;
      SEL_CTRL: begin
        reg_rdata[CTRL_EN_BIT]          = en_q;
        reg_rdata[SIZE_LSB +: SIZE_W]   = size_q;
      end
      SEL_BASE_LO: reg_rdata = base_lo_q;
      SEL_BASE_HI: reg_rdata = base_hi_q;
      default:     reg_rdata = '0;
    endcase
  end

  assign en_o       = en_q;
  assign last_bus_o = size_q;
  assign base_o     = {base_hi_q, base_lo_q};

endmodule

// File: rtl/cfgx_gate.sv
module cfgx_gate #(
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned DEVFN_W  = 8,
  parameter int unsigned SIZE_W   = 5,
  parameter int unsigned ROOT_BUS = 0
) (
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic               link_up,
  input  logic               en,
  input  logic [SIZE_W-1:0]  last_bus,
  output logic               reach_ok
);
  logic on_root;
  logic root_blocked;
  logic link_blocked;
  logic range_blocked;

  assign on_root       = (bus == BUS_W'(ROOT_BUS));
  assign root_blocked  = on_root && (devfn != '0);
  assign link_blocked  = !on_root && !link_up;
  assign range_blocked = bus > {{(BUS_W-SIZE_W){1'b0}}, last_bus};
  assign reach_ok      = en && !root_blocked && !link_blocked && !range_blocked;

endmodule

// File: rtl/cfgx_resp.sv
module cfgx_resp #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned DEVFN_W = 8,
  parameter int unsigned OFF_W   = 12,
  localparam int unsigned LOC_W  = BUS_W + DEVFN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic               ok,
  input  logic               is_write,
  input  logic [BUS_W-1:0]   bus,
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [OFF_W-1:0]   offset,
  input  logic [ADDR_W-1:0]  base,
  output logic               rsp_valid,
  output logic               rsp_rejected,
  output logic               rsp_write,
  output logic               rsp_wr_en,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic [DATA_W-1:0]  rsp_data
);
  // Bus sits above devfn, devfn above the register offset.
  function automatic logic [ADDR_W-1:0] window_offset(
    input logic [BUS_W-1:0]   b,
    input logic [DEVFN_W-1:0] d,
    input logic [OFF_W-1:0]   o
  );
    return {{(ADDR_W-LOC_W){1'b0}}, b, d, o};
  endfunction

  logic [ADDR_W-1:0] xlated;
  assign xlated = base + window_offset(bus, devfn, offset);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_rejected <= 1'b0;
      rsp_write    <= 1'b0;
      rsp_wr_en    <= 1'b0;
      rsp_addr     <= '0;
      rsp_data     <= '0;
    end else if (fire) begin
      rsp_valid    <= 1'b1;
      rsp_rejected <= !ok;
      rsp_write    <= is_write;
      rsp_wr_en    <= is_write && ok;
      rsp_addr     <= ok ? xlated : '0;
      rsp_data     <= (!ok && !is_write) ? '1 : '0;
    end else begin
      rsp_valid    <= 1'b0;
      rsp_wr_en    <= 1'b0;
    end
  end

endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned DEVFN_W  = 8,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned ROOT_BUS = 0,
  parameter int unsigned SIZE_RST = 12,
  localparam int unsigned ADDR_W  = 2 * DATA_W,
  localparam int unsigned SIZE_W  = cfgx_pkg::CTRL_SZ_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [1:0]         reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               link_up,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [BUS_W-1:0]   req_bus,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [OFF_W-1:0]   req_offset,
  input  logic               req_write,
  output logic               rsp_valid,
  output logic               rsp_rejected,
  output logic               rsp_write,
  output logic               rsp_wr_en,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic [DATA_W-1:0]  rsp_data
);
  logic              ctrl_en;
  logic [SIZE_W-1:0] last_bus;
  logic [ADDR_W-1:0] win_base;
  logic              reach_ok;
  logic              req_fire;

  assign req_ready = 1'b1;
  assign req_fire  = req_valid && req_ready;

  cfgx_regs #(
    .DATA_W  (DATA_W),
    .SIZE_W  (SIZE_W),
    .SIZE_LSB(cfgx_pkg::CTRL_SZ_LSB),
    .SIZE_RST(SIZE_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .en_o      (ctrl_en),
    .last_bus_o(last_bus),
    .base_o    (win_base)
  );

  cfgx_gate #(
    .BUS_W   (BUS_W),
    .DEVFN_W (DEVFN_W),
    .SIZE_W  (SIZE_W),
    .ROOT_BUS(ROOT_BUS)
  ) u_gate (
    .bus     (req_bus),
    .devfn   (req_devfn),
    .link_up (link_up),
    .en      (ctrl_en),
    .last_bus(last_bus),
    .reach_ok(reach_ok)
  );

  cfgx_resp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BUS_W  (BUS_W),
    .DEVFN_W(DEVFN_W),
    .OFF_W  (OFF_W)
  ) u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (req_fire),
    .ok          (reach_ok),
    .is_write    (req_write),
    .bus         (req_bus),
    .devfn       (req_devfn),
    .offset      (req_offset),
    .base        (win_base),
    .rsp_valid   (rsp_valid),
    .rsp_rejected(rsp_rejected),
    .rsp_write   (rsp_write),
    .rsp_wr_en   (rsp_wr_en),
    .rsp_addr    (rsp_addr),
    .rsp_data    (rsp_data)
  );

endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned DEVFN_W  = 8,
  parameter int unsigned ROOT_BUS = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [BUS_W-1:0]   req_bus,
  input logic [DEVFN_W-1:0] req_devfn,
  input logic               link_up,
  input logic               en,
  input logic [1:0]         reg_sel,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               rsp_valid,
  input logic               rsp_rejected,
  input logic               rsp_write,
  input logic               rsp_wr_en,
  input logic [DATA_W-1:0]  rsp_data
);

  a_r11_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  a_r5_disabled_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !en) |=> rsp_rejected);

  a_r2_root_devfn: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_bus == BUS_W'(ROOT_BUS) && req_devfn != '0) |=> rsp_rejected);

  a_r3_link_down: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_bus != BUS_W'(ROOT_BUS) && !link_up) |=> rsp_rejected);

  a_r6_reject_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_rejected && !rsp_write) |-> (rsp_data == '1));

  a_r6_reject_write_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_rejected) |-> !rsp_wr_en);

  a_r8_cap_present: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (reg_rdata == DATA_W'(1)));

endmodule

bind cfg_addr_xlate cfgx_chk #(
  .DATA_W  (DATA_W),
  .BUS_W   (BUS_W),
  .DEVFN_W (DEVFN_W),
  .ROOT_BUS(ROOT_BUS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_bus     (req_bus),
  .req_devfn   (req_devfn),
  .link_up     (link_up),
  .en          (ctrl_en),
  .reg_sel     (reg_sel),
  .reg_rdata   (reg_rdata),
  .rsp_valid   (rsp_valid),
  .rsp_rejected(rsp_rejected),
  .rsp_write   (rsp_write),
  .rsp_wr_en   (rsp_wr_en),
  .rsp_data    (rsp_data)
);

// File: tb/tb_cfg_addr_xlate.sv
module tb_cfg_addr_xlate;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        link_up;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_bus;
  logic [7:0]  req_devfn;
  logic [11:0] req_offset;
  logic        req_write;
  logic        rsp_valid;
  logic        rsp_rejected;
  logic        rsp_write;
  logic        rsp_wr_en;
  logic [63:0] rsp_addr;
  logic [31:0] rsp_data;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  // reference model state
  bit          m_en;
  int unsigned m_size;
  bit [31:0]   m_lo, m_hi;

  bit              q_rej[$];
  bit              q_wr[$];
  longint unsigned q_addr[$];
  string           q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_addr_xlate dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
    .req_valid(req_valid), .req_ready(req_ready), .req_bus(req_bus),
    .req_devfn(req_devfn), .req_offset(req_offset), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_rejected(rsp_rejected), .rsp_write(rsp_write),
    .rsp_wr_en(rsp_wr_en), .rsp_addr(rsp_addr), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic compare();
    bit exp_v;
    exp_v = (q_rej.size() > 0);
    chk(rsp_valid === exp_v, "R11 rsp_valid", longint'(rsp_valid), longint'(exp_v));
    if (exp_v) begin
      bit r, w;
      longint unsigned a;
      string t;
      r = q_rej.pop_front(); w = q_wr.pop_front();
      a = q_addr.pop_front(); t = q_tag.pop_front();
      chk(rsp_rejected === r, {t, " rejected"}, longint'(rsp_rejected), longint'(r));
      chk(rsp_wr_en === (w && !r), {t, " R6 wr_en"}, longint'(rsp_wr_en), longint'(w && !r));
      chk(rsp_data === ((r && !w) ? 32'hFFFF_FFFF : 32'h0), {t, " R6 data"},
          longint'(rsp_data), (r && !w) ? 64'hFFFF_FFFF : 64'h0);
      chk(rsp_addr === a, {t, " R1 addr"}, rsp_addr, a);
    end
  endtask

  task automatic step(input bit rv, input int b, input int d, input int o, input bit w,
                      input bit lk, input bit we, input int sel, input bit [31:0] wd,
                      input string tag);
    @(negedge clk);
    cycles++;
    compare();
    req_valid = rv; req_bus = 8'(b); req_devfn = 8'(d); req_offset = 12'(o);
    req_write = w; link_up = lk; reg_we = we; reg_sel = 2'(sel); reg_wdata = wd;
    if (rv) begin
      bit rej;
      longint unsigned loc, base;
      rej = !m_en;
      if (b == 0 && d != 0) rej = 1;
      if (b != 0 && !lk) rej = 1;
      if (b > int'(m_size)) rej = 1;
      loc  = (longint'(b) << 20) + (longint'(d) << 12) + longint'(o);
      base = {m_hi, m_lo};
      q_rej.push_back(rej);
      q_wr.push_back(w);
      q_addr.push_back(rej ? 64'h0 : base + loc);
      q_tag.push_back(tag);
    end
    if (we) begin
      case (sel)
        1: begin m_en = wd[0]; m_size = int'(wd[20:16]); end
        2: m_lo = wd;
        3: m_hi = wd;
        default: ;
      endcase
    end
  endtask

  task automatic req(input int b, input int d, input int o, input bit w, input bit lk,
                     input string tag);
    step(1, b, d, o, w, lk, 0, 0, 0, tag);
  endtask

  task automatic wreg(input int sel, input bit [31:0] wd);
    step(0, 0, 0, 0, 0, 1, 1, sel, wd, "");
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "");
  endtask

  task automatic rd(input int sel, input bit [31:0] exp, input string tag);
    step(0, 0, 0, 0, 0, 1, 0, sel, 0, tag);
    #1;
    chk(reg_rdata === exp, tag, longint'(reg_rdata), longint'(exp));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        summary();
      end
    end
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0; link_up = 1;
    req_valid = 0; req_bus = 0; req_devfn = 0; req_offset = 0; req_write = 0;
    m_en = 0; m_size = 12; m_lo = 0; m_hi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R7 reset state
    rd(1, 32'h000C_0000, "R7 ctrl reset");
    rd(2, 32'h0, "R7 base lo reset");
    rd(3, 32'h0, "R7 base hi reset");
    rd(0, 32'h1, "R8 capability");
    wreg(0, 32'h0);
    rd(0, 32'h1, "R8 capability after write");
    // R5 disabled
    req(0, 0, 12'h10, 0, 1, "R5 disabled read");
    req(1, 0, 0, 1, 1, "R5 disabled write");
    // R9 register writes
    wreg(2, 32'h4000_0000);
    wreg(3, 32'h0000_0005);
    rd(2, 32'h4000_0000, "R9 base lo");
    rd(3, 32'h0000_0005, "R9 base hi");
    wreg(1, 32'hA5C3_5A55);
    rd(1, 32'h0003_0001, "R9 ctrl masked");
    wreg(1, 32'h000C_0001);
    // R1 root accepted
    req(0, 0, 12'h3FC, 0, 1, "R1 root read");
    req(0, 0, 12'h040, 1, 1, "R1 root write");
    // R2 root devfn filter
    req(0, 3, 0, 0, 1, "R2 root devfn3");
    req(0, 1, 0, 1, 1, "R2 root devfn1 write");
    // R3 link gating
    req(1, 8'h08, 12'h100, 0, 1, "R3 link up");
    req(1, 8'h08, 12'h100, 0, 0, "R3 link down");
    req(5, 0, 4, 1, 0, "R3 link down write");
    req(0, 0, 8, 0, 0, "R3 root ignores link");
    // R4 bus range
    req(12, 8'hFF, 12'hFFF, 0, 1, "R4 last bus");
    req(13, 0, 0, 0, 1, "R4 beyond last");
    req(255, 0, 0, 0, 1, "R4 bus 255");
    wreg(1, 32'h0001_0001);
    req(2, 0, 0, 0, 1, "R4 small size reject");
    req(1, 0, 0, 0, 1, "R4 small size accept");
    wreg(1, 32'h000C_0001);
    // R6 local completion
    req(1, 0, 0, 1, 0, "R6 rejected write");
    req(0, 2, 0, 0, 1, "R6 rejected read");
    // R1 carry into high half
    wreg(2, 32'hFFF0_0000);
    req(3, 8'h10, 12'h020, 0, 1, "R1 carry");
    idle();
    // R10 same-cycle register write and request
    step(1, 2, 0, 0, 0, 1, 1, 1, 32'h000C_0000, "R10 old enable");
    req(2, 0, 0, 0, 1, "R10 new disable");
    step(1, 2, 0, 0, 0, 1, 1, 1, 32'h000C_0001, "R10 old disable");
    req(2, 0, 0, 0, 1, "R10 new enable");
    step(1, 12, 0, 0, 0, 1, 1, 1, 32'h000B_0001, "R10 old size");
    req(12, 0, 0, 0, 1, "R10 new size");
    // R11 gaps and flush
    idle();
    idle();
    req(0, 0, 4, 0, 1, "R11 after gap");
    idle();
    idle();
    summary();
  end

endmodule